// File: doc/BRIEF.md
# Identification Register Bank

This block is a read-only bank of 64-bit identification registers selected by an 8-bit register number. Registers 0 through 4 always exist. Registers 5 and up form an implementation-sized region whose extent is a parameter. Registers 0 and 1 carry a 16-byte ASCII vendor name. Register 2 is a hole that always reads zero. Register 3 packs the version fields together with a count field that sets the highest readable register number. Every value is fixed at elaboration, and the block has no way to write any of them.

A read is a request/response pair. The requester presents an index with `req_valid`. The block takes it when `req_ready` is high. One clock later it presents a single response: either the 64-bit value, or a reserved-register fault with zero data. `req_ready` is high whenever the response slot is empty, or when it is being drained in the same cycle. Holding `rsp_ready` low therefore stalls new requests and freezes the pending response. No request is dropped and none is duplicated.

Top module: `ident_regfile`

## Requirements
- R1: While reset is applied and in the first cycle after it, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Vendor byte k, for k from 0 to 15, appears in bits [8(k mod 8)+7 : 8(k mod 8)]. It is in register 0 when k < 8 and in register 1 otherwise.
- R3: Once a zero byte ends the vendor name, that byte and every later byte up to byte 15 read as zero, whatever the parameter holds there.
- R4: A read of register 2 returns all zeros and no fault.
- R5: Register 3 reads as count [7:0], revision [15:8], model [23:16], family [31:24], architecture revision [39:32]. Bits [63:40] read zero.
- R6: An index greater than the count field in register 3 returns a fault, and the fault response always carries zero data.
- R7: An index at or above the number of implemented registers (`NUM_REGS`) faults, even when the count field is larger.
- R8: Registers 4 through `NUM_REGS`-1 return their per-register parameter value without a fault, as long as the index is within the count field.
- R9: A request accepted on one rising edge gives `rsp_valid` high right after the next edge. Responses come out in request order.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_fault` hold steady, `req_ready` is low, and no request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A read request is offered |
| req_ready | output | 1 | The block can take a request this cycle |
| req_index | input | 8 | Register number to read |
| rsp_valid | output | 1 | A response is held for the consumer |
| rsp_ready | input | 1 | The consumer takes the response this cycle |
| rsp_data | output | 64 | Register value, zero on a fault |
| rsp_fault | output | 1 | Reserved-register fault for the request |

## Verification
Each accepted request has its response due exactly one cycle after the edge that took it. A stalled response stays due for as long as `rsp_ready` stays low. The bench drives inputs shortly after a rising edge and samples on the falling edge. It notes each handshake it sees and requires `rsp_valid` at the following falling edge. It pushes the expected value and fault for every request into a queue, and pops and compares an entry only at a falling edge where `rsp_valid` and `rsp_ready` are both high. A second instance, whose count field is larger than its register count, runs in lockstep from the same stimulus and is checked against its own queue.

// File: rtl/idreg_pkg.sv
package idreg_pkg;

  localparam int REG_W     = 64;
  localparam int IDX_W     = 8;
  localparam int VENDOR_B  = 16;
  localparam int FIXED_CNT = 5;

  typedef logic [REG_W-1:0] word_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic [23:0] zero_hi;
    logic [7:0]  arch_rev;
    logic [7:0]  family;
    logic [7:0]  model;
    logic [7:0]  revision;
    logic [7:0]  count;
  } version_t;

  // Zero the terminating NUL byte and everything that follows it.
  function automatic logic [8*VENDOR_B-1:0] trim_vendor(input logic [8*VENDOR_B-1:0] raw);
    logic [8*VENDOR_B-1:0] res;
    logic ended;
    res   = '0;
    ended = 1'b0;
    for (int b = 0; b < VENDOR_B; b++) begin
      if (raw[8*b +: 8] == 8'h00) ended = 1'b1;
      if (!ended) res[8*b +: 8] = raw[8*b +: 8];
    end
    return res;
  endfunction

  function automatic word_t make_version(input logic [7:0] cnt, input logic [7:0] rev,
                                         input logic [7:0] mdl, input logic [7:0] fam,
                                         input logic [7:0] arch);
    version_t v;
    v.zero_hi  = '0;
    v.arch_rev = arch;
    v.family   = fam;
    v.model    = mdl;
    v.revision = rev;
    v.count    = cnt;
    return word_t'(v);
  endfunction

endpackage

// File: rtl/idreg_rom.sv
module idreg_rom
  import idreg_pkg::*;
#(
  parameter int                               NUM_REGS   = 5,
  parameter logic [8*VENDOR_B-1:0]            VENDOR_RAW = '0,
  parameter logic [7:0]                       COUNT_FLD  = 8'd4,
  parameter logic [7:0]                       REVISION   = 8'h00,
  parameter logic [7:0]                       MODEL      = 8'h00,
  parameter logic [7:0]                       FAMILY     = 8'h00,
  parameter logic [7:0]                       ARCH_REV   = 8'h00,
  parameter logic [NUM_REGS-5:0][REG_W-1:0]   MISC_VALS  = '0
) (
  input  idx_t  idx,
  output word_t value
);

  localparam logic [8*VENDOR_B-1:0] VENDOR_CLEAN = trim_vendor(VENDOR_RAW);
  localparam word_t                 VERSION_WORD =
    make_version(COUNT_FLD, REVISION, MODEL, FAMILY, ARCH_REV);

  word_t entries [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
    if (r == 0) begin : g_vend_lo
      assign entries[r] = VENDOR_CLEAN[REG_W-1:0];
    end else if (r == 1) begin : g_vend_hi
      assign entries[r] = VENDOR_CLEAN[2*REG_W-1:REG_W];
    end else if (r == 2) begin : g_hole
      assign entries[r] = '0;
    end else if (r == 3) begin : g_version
      assign entries[r] = VERSION_WORD;
    end else begin : g_misc
      assign entries[r] = MISC_VALS[r-4];
    end
  end

  always_comb begin
    value = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (idx == IDX_W'(k)) value = entries[k];
    end
  end

endmodule

// File: rtl/idreg_limit.sv
module idreg_limit
  import idreg_pkg::*;
#(
  parameter int         NUM_REGS  = 5,
  parameter logic [7:0] COUNT_FLD = 8'd4
) (
  input  idx_t idx,
  output logic fault
);

  // The readable ceiling is the smaller of the count field and the last built register.
  localparam int   TOP_BUILT = NUM_REGS - 1;
  localparam int   CEILING   = (int'(COUNT_FLD) < TOP_BUILT) ? int'(COUNT_FLD) : TOP_BUILT;
  localparam idx_t CEIL_IDX  = IDX_W'(CEILING);

  assign fault = (idx > CEIL_IDX);

endmodule

// File: rtl/idreg_rsp_stage.sv
module idreg_rsp_stage
  import idreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  drain,
  input  word_t data_in,
  input  logic  fault_in,
  output logic  valid_q,
  output word_t data_q,
  output logic  fault_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      fault_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= data_in;
      fault_q <= fault_in;
    end else if (drain) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ident_regfile.sv
module ident_regfile
  import idreg_pkg::*;
#(
  parameter int                               NUM_REGS   = 5,
  parameter logic [8*VENDOR_B-1:0]            VENDOR_RAW = '0,
  parameter logic [7:0]                       COUNT_FLD  = 8'(NUM_REGS - 1),
  parameter logic [7:0]                       REVISION   = 8'h00,
  parameter logic [7:0]                       MODEL      = 8'h00,
  parameter logic [7:0]                       FAMILY     = 8'h00,
  parameter logic [7:0]                       ARCH_REV   = 8'h00,
  parameter logic [NUM_REGS-5:0][REG_W-1:0]   MISC_VALS  = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_index,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [63:0] rsp_data,
  output logic        rsp_fault
);

  word_t lookup;
  logic  bad_idx;
  logic  take;
  logic  give;

  idreg_rom #(
    .NUM_REGS  (NUM_REGS),
    .VENDOR_RAW(VENDOR_RAW),
    .COUNT_FLD (COUNT_FLD),
    .REVISION  (REVISION),
    .MODEL     (MODEL),
    .FAMILY    (FAMILY),
    .ARCH_REV  (ARCH_REV),
    .MISC_VALS (MISC_VALS)
  ) u_rom (
    .idx  (req_index),
    .value(lookup)
  );

  idreg_limit #(
    .NUM_REGS (NUM_REGS),
    .COUNT_FLD(COUNT_FLD)
  ) u_limit (
    .idx  (req_index),
    .fault(bad_idx)
  );

  assign give      = rsp_valid & rsp_ready;
  assign req_ready = ~rsp_valid | rsp_ready;
  assign take      = req_valid & req_ready;

  idreg_rsp_stage u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .drain   (give),
    .data_in (bad_idx ? '0 : lookup),
    .fault_in(bad_idx),
    .valid_q (rsp_valid),
    .data_q  (rsp_data),
    .fault_q (rsp_fault)
  );

endmodule

// File: rtl/idreg_checker.sv
module idreg_checker #(
  parameter int         NUM_REGS  = 5,
  parameter logic [7:0] COUNT_FLD = 8'd4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [7:0]  req_index,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_data,
  input logic        rsp_fault
);

  wire accepted = req_valid && req_ready;

  // R1: response slot is empty right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  // R9: a taken request produces a response on the next cycle
  a_r9_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> rsp_valid);

  // R10: a stalled response is frozen and blocks intake
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_fault)));

  a_r10_no_intake_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R6: fault responses carry zero data
  a_r6_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_data == 64'd0));

  // R6: index above count field faults
  a_r6_above_count: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && (req_index > COUNT_FLD)) |=> rsp_fault);

  // R7: index past the built registers faults
  a_r7_past_built: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && (int'(req_index) >= NUM_REGS)) |=> rsp_fault);

  // R4: register 2 reads zero without fault
  a_r4_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && (req_index == 8'd2)) |=> (!rsp_fault && rsp_data == 64'd0));

  // R5: upper version bits are zero
  a_r5_version_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && (req_index == 8'd3)) |=> (rsp_data[63:40] == 24'd0));

endmodule

bind ident_regfile idreg_checker #(
  .NUM_REGS (NUM_REGS),
  .COUNT_FLD(COUNT_FLD)
) u_idreg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_index(req_index),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .rsp_fault(rsp_fault)
);

// File: tb/test_ident_regfile.sv
module test_ident_regfile;

  typedef struct {
    logic [63:0] data;
    logic        fault;
    int          idx;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_index = 8'd0;
  logic        rsp_ready = 1'b1;
  logic        req_ready_a, req_ready_b;
  logic        rsp_valid_a, rsp_valid_b;
  logic [63:0] rsp_data_a, rsp_data_b;
  logic        rsp_fault_a, rsp_fault_b;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  exp_t q_a[$];
  exp_t q_b[$];

  always #4 clk = ~clk;

  // Main instance: 8 registers, count field 6, string ends early with junk after it.
  ident_regfile #(
    .NUM_REGS  (8),
    .VENDOR_RAW(128'h5252_5252_5252_5252_5252_5100_656D_6341),
    .COUNT_FLD (8'd6),
    .REVISION  (8'h11),
    .MODEL     (8'h22),
    .FAMILY    (8'h33),
    .ARCH_REV  (8'h44),
    .MISC_VALS ({64'h7777_0000_0000_0007, 64'h6666_0000_0000_0006,
                 64'h5555_0000_0000_0005, 64'h4444_0000_0000_0004})
  ) i_ident_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_a),
    .req_index(req_index), .rsp_valid(rsp_valid_a), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data_a), .rsp_fault(rsp_fault_a)
  );

  // Second instance: 6 registers, count field set too high, full 16-char name.
  ident_regfile #(
    .NUM_REGS  (6),
    .VENDOR_RAW(128'h4847_4645_4443_4241_3837_3635_3433_3231),
    .COUNT_FLD (8'd40),
    .REVISION  (8'h01),
    .MODEL     (8'h02),
    .FAMILY    (8'h03),
    .ARCH_REV  (8'h04),
    .MISC_VALS ({64'hBBBB_0000_0000_0005, 64'hAAAA_0000_0000_0004})
  ) i_ident_regfile_over (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_b),
    .req_index(req_index), .rsp_valid(rsp_valid_b), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data_b), .rsp_fault(rsp_fault_b)
  );

  function automatic exp_t model_a(input int idx);
    exp_t e;
    e.idx = idx; e.fault = 1'b0; e.data = 64'd0;
    case (idx)
      0: begin e.data = 64'h0000_0000_656D_6341; e.req = "R2/R3"; end
      1: begin e.data = 64'd0; e.req = "R3"; end
      2: begin e.data = 64'd0; e.req = "R4"; end
      3: begin e.data = 64'h0000_0044_3322_1106; e.req = "R5"; end
      4: begin e.data = 64'h4444_0000_0000_0004; e.req = "R8"; end
      5: begin e.data = 64'h5555_0000_0000_0005; e.req = "R8"; end
      6: begin e.data = 64'h6666_0000_0000_0006; e.req = "R8"; end
      default: begin e.fault = 1'b1; e.req = "R6"; end
    endcase
    return e;
  endfunction

  function automatic exp_t model_b(input int idx);
    exp_t e;
    e.idx = idx; e.fault = 1'b0; e.data = 64'd0;
    case (idx)
      0: begin e.data = 64'h3837_3635_3433_3231; e.req = "R2"; end
      1: begin e.data = 64'h4847_4645_4443_4241; e.req = "R2"; end
      2: begin e.data = 64'd0; e.req = "R4"; end
      3: begin e.data = 64'h0000_0004_0302_0128; e.req = "R5"; end
      4: begin e.data = 64'hAAAA_0000_0000_0004; e.req = "R8"; end
      5: begin e.data = 64'hBBBB_0000_0000_0005; e.req = "R8"; end
      default: begin e.fault = 1'b1; e.req = "R7"; end
    endcase
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input int idx);
    @(posedge clk); #2;
    req_valid = 1'b1;
    req_index = 8'(idx);
    q_a.push_back(model_a(idx));
    q_b.push_back(model_b(idx));
    do @(negedge clk); while (!req_ready_a);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  // Monitor: pop and compare on falling edges where the response is drained.
  bit          took_prev = 1'b0;
  bit          hold_prev = 1'b0;
  logic [63:0] hold_d;
  logic        hold_f;

  always @(negedge clk) begin
    if (rst_n) begin
      if (took_prev)
        check(rsp_valid_a == 1'b1, "R9", "rsp_valid one cycle after accept", 64'(rsp_valid_a), 64'd1);
      if (hold_prev) begin
        check(rsp_valid_a && rsp_data_a == hold_d && rsp_fault_a == hold_f,
              "R10", "stalled response changed", rsp_data_a, hold_d);
        check(req_ready_a == 1'b0 || rsp_ready, "R10", "req_ready during stall",
              64'(req_ready_a), 64'd0);
      end
      if (rsp_valid_a && rsp_ready) begin
        if (q_a.size() == 0) begin
          check(1'b0, "R9", "unexpected response", rsp_data_a, 64'd0);
        end else begin
          exp_t e;
          e = q_a.pop_front();
          check(rsp_data_a == e.data && rsp_fault_a == e.fault, e.req,
                $sformatf("main idx %0d data/fault", e.idx),
                {rsp_data_a[62:0], rsp_fault_a}, {e.data[62:0], e.fault});
          if (e.fault)
            check(rsp_data_a == 64'd0, "R6", "fault data not zero", rsp_data_a, 64'd0);
        end
      end
      if (rsp_valid_b && rsp_ready) begin
        if (q_b.size() == 0) begin
          check(1'b0, "R9", "unexpected response (second)", rsp_data_b, 64'd0);
        end else begin
          exp_t e;
          e = q_b.pop_front();
          check(rsp_data_b == e.data && rsp_fault_b == e.fault, e.req,
                $sformatf("second idx %0d data/fault", e.idx),
                {rsp_data_b[62:0], rsp_fault_b}, {e.data[62:0], e.fault});
        end
      end
      took_prev = req_valid && req_ready_a;
      hold_prev = rsp_valid_a && !rsp_ready;
      hold_d    = rsp_data_a;
      hold_f    = rsp_fault_a;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid_a == 1'b0 && req_ready_a == 1'b1, "R1", "state in reset",
          {62'd0, rsp_valid_a, req_ready_a}, 64'd1);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid_a == 1'b0 && req_ready_a == 1'b1, "R1", "state after reset",
          {62'd0, rsp_valid_a, req_ready_a}, 64'd1);

    // Streaming sweep across every region and past the end.
    for (int i = 0; i < 10; i++) send(i);
    send(255);
    send(40);
    send(41);

    // Stall: first response held, second request waits.
    rsp_ready = 1'b0;
    fork
      begin send(3); send(6); send(2); end
      begin repeat (6) @(posedge clk); #2; rsp_ready = 1'b1; end
    join

    // Alternating back-pressure over a mixed order.
    fork
      begin send(7); send(0); send(5); send(1); send(4); end
      begin
        for (int t = 0; t < 12; t++) begin
          @(posedge clk); #2;
          rsp_ready = (t % 3) != 0;
        end
        rsp_ready = 1'b1;
      end
    join

    repeat (4) @(posedge clk);
    check(q_a.size() == 0 && q_b.size() == 0, "R9", "responses outstanding",
          64'(q_a.size() + q_b.size()), 64'd0);
    finish_run();
  end

endmodule